// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the status word of a 16-bit microcontroller core. The word has eight single-bit flags and a 3-bit interrupt priority level:

- **Condition flags:** carry, zero, overflow and negative.
- **Mode flags:** interrupt disable, decimal mode, index width and accumulator width.

The register is read through a 16-bit bus whose top five bits are always zero. Each flag is also brought out on a wire of its own. A mask-enable output tells the interrupt logic when maskable requests may pass. An index-width output tells the index registers whether they run 16 or 8 bits wide.

Five update sources can change the register, and they are resolved bit by bit in a fixed priority order:

1. Interrupt acceptance.
2. Mask-based set/clear commands, together with the dedicated carry and interrupt-disable strobes.
3. A full-word write.
4. Per-flag updates from the arithmetic unit.

A synchronous reset overrides all of them and loads the start-up value. While the decimal-mode flag is 1, the zero flag produced by a decimal add is undefined. The register stores whatever the arithmetic unit supplies and gives that value no meaning.

Top module: `proc_status`

## Requirements
- R1: The read bus carries carry at bit 0, zero at bit 1, interrupt disable at bit 2, decimal mode at bit 3, index width at bit 4, accumulator width at bit 5, overflow at bit 6, negative at bit 7 and the priority level at bits 10:8. Each individual output equals its bus bit.
- R2: Bits 15:11 of the read bus are always 0, whatever value was written.
- R3: A synchronous active-high reset loads interrupt disable = 1 and every other flag and the priority level = 0, so the bus reads 16'h0004 after reset. Reset overrides every other source.
- R4: An interrupt-accept pulse sets interrupt disable to 1 on the next edge. This holds even when a clear of that flag is requested in the same cycle. The other bits follow the lower sources.
- R5: The mask-enable output is 1 exactly when interrupt disable is 0. The index-wide output is 1 exactly when the index-width flag (bit 4) is 0.
- R6: A mask-set command sets every low flag whose mask bit is 1. Bits whose mask bit is 0 are left to the lower sources.
- R7: A mask-clear command clears every low flag whose mask bit is 1. When a bit is both set and cleared in one cycle, the set wins.
- R8: The dedicated carry set/clear and interrupt-disable set/clear strobes act as single-bit set/clear commands. They have the same rank as the mask commands, and set wins over clear.
- R9: A full write loads bits 10:0 from the write data, except for flag bits claimed by interrupt acceptance or a set/clear command. The priority level changes only through a full write or reset.
- R10: The arithmetic unit updates each flag k with aluFlagEn[k] = 1 to aluFlags[k], but only when no higher source touches that bit. It never changes the priority level.
- R11: With no source active, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| aluFlagEn | input | 8 | Per-flag update enable from the arithmetic unit |
| aluFlags | input | 8 | Flag values from the arithmetic unit |
| maskSet | input | 1 | Set the low flags selected by maskBits |
| maskClr | input | 1 | Clear the low flags selected by maskBits |
| maskBits | input | 8 | Flag selection mask for set/clear |
| carrySet | input | 1 | Set the carry flag |
| carryClr | input | 1 | Clear the carry flag |
| intDisSet | input | 1 | Set the interrupt-disable flag |
| intDisClr | input | 1 | Clear the interrupt-disable flag |
| irqAccept | input | 1 | An interrupt request was accepted this cycle |
| wrEn | input | 1 | Full-word write enable |
| wrData | input | 16 | Full-word write data |
| rdData | output | 16 | Status word read bus |
| carry | output | 1 | Carry flag |
| zero | output | 1 | Zero flag |
| intDisable | output | 1 | Interrupt-disable flag |
| decimalMode | output | 1 | Decimal arithmetic mode flag |
| indexNarrow | output | 1 | Index registers are 8-bit |
| accNarrow | output | 1 | Accumulator-width mode flag |
| overflow | output | 1 | Overflow flag |
| negative | output | 1 | Negative flag |
| prioLevel | output | 3 | Interrupt priority level |
| maskEnable | output | 1 | Maskable interrupts may pass |
| indexWide | output | 1 | Index registers are 16-bit |

## Verification
Every update source takes effect on the first rising edge after it is presented. The outputs are combinational views of the stored word, so each result is due exactly one clock after its stimulus. The bench drives inputs on the falling edge and removes them at the next falling edge. It then compares the outputs in that same falling-edge slot, half a cycle after the edge that stored the result. Conflicting sources are presented together in a single cycle, so each priority case is settled by one edge and one comparison.

// File: rtl/proc_status_pkg.sv
package proc_status_pkg;

  localparam int FLAG_W = 8;
  localparam int IPL_W  = 3;
  localparam int BUS_W  = 16;
  localparam int PAD_W  = BUS_W - FLAG_W - IPL_W;

  localparam int CARRY_BIT = 0;
  localparam int ZERO_BIT  = 1;
  localparam int IDIS_BIT  = 2;
  localparam int DEC_BIT   = 3;
  localparam int IDX_BIT   = 4;
  localparam int ACC_BIT   = 5;
  localparam int OVF_BIT   = 6;
  localparam int NEG_BIT   = 7;

  localparam logic [FLAG_W-1:0] FLAG_RESET = FLAG_W'(1) << IDIS_BIT;
  localparam logic [IPL_W-1:0]  IPL_RESET  = '0;

  typedef struct packed {
    logic [FLAG_W-1:0] forceOne;
    logic [FLAG_W-1:0] forceZero;
    logic [FLAG_W-1:0] loadWr;
    logic [FLAG_W-1:0] loadAlu;
    logic              loadIpl;
  } statusStrobes_t;

endpackage

// File: rtl/proc_status_ctrl.sv
module proc_status_ctrl
  import proc_status_pkg::*;
(
  input  logic [FLAG_W-1:0] aluFlagEn,
  input  logic              maskSet,
  input  logic              maskClr,
  input  logic [FLAG_W-1:0] maskBits,
  input  logic              carrySet,
  input  logic              carryClr,
  input  logic              intDisSet,
  input  logic              intDisClr,
  input  logic              irqAccept,
  input  logic              wrEn,
  output statusStrobes_t    strobes
);

  logic [FLAG_W-1:0] setVec;
  logic [FLAG_W-1:0] clrVec;
  logic [FLAG_W-1:0] claimed;

  always_comb begin
    setVec = maskSet ? maskBits : '0;
    setVec[CARRY_BIT] = setVec[CARRY_BIT] | carrySet;
    setVec[IDIS_BIT]  = setVec[IDIS_BIT] | intDisSet | irqAccept;

    clrVec = maskClr ? maskBits : '0;
    clrVec[CARRY_BIT] = clrVec[CARRY_BIT] | carryClr;
    clrVec[IDIS_BIT]  = clrVec[IDIS_BIT] | intDisClr;

    claimed = setVec | clrVec;

    strobes.forceOne  = setVec;
    strobes.forceZero = clrVec & ~setVec;
    strobes.loadWr    = wrEn ? ~claimed : '0;
    strobes.loadAlu   = wrEn ? '0 : (aluFlagEn & ~claimed);
    strobes.loadIpl   = wrEn;
  end

endmodule

// File: rtl/proc_status_path.sv
module proc_status_path
  import proc_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  statusStrobes_t    strobes,
  input  logic [BUS_W-1:0]  wrData,
  input  logic [FLAG_W-1:0] aluFlags,
  output logic [FLAG_W-1:0] flagQ,
  output logic [IPL_W-1:0]  iplQ,
  output logic [BUS_W-1:0]  rdData
);

  for (genvar k = 0; k < FLAG_W; k++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                      flagQ[k] <= FLAG_RESET[k];
      else if (strobes.forceOne[k]) flagQ[k] <= 1'b1;
      else if (strobes.forceZero[k]) flagQ[k] <= 1'b0;
      else if (strobes.loadWr[k])   flagQ[k] <= wrData[k];
      else if (strobes.loadAlu[k])  flagQ[k] <= aluFlags[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  iplQ <= IPL_RESET;
    else if (strobes.loadIpl) iplQ <= wrData[FLAG_W +: IPL_W];
  end

  assign rdData = {{PAD_W{1'b0}}, iplQ, flagQ};

endmodule

// File: rtl/proc_status.sv
module proc_status
  import proc_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_W-1:0] aluFlagEn,
  input  logic [FLAG_W-1:0] aluFlags,
  input  logic              maskSet,
  input  logic              maskClr,
  input  logic [FLAG_W-1:0] maskBits,
  input  logic              carrySet,
  input  logic              carryClr,
  input  logic              intDisSet,
  input  logic              intDisClr,
  input  logic              irqAccept,
  input  logic              wrEn,
  input  logic [BUS_W-1:0]  wrData,
  output logic [BUS_W-1:0]  rdData,
  output logic              carry,
  output logic              zero,
  output logic              intDisable,
  output logic              decimalMode,
  output logic              indexNarrow,
  output logic              accNarrow,
  output logic              overflow,
  output logic              negative,
  output logic [IPL_W-1:0]  prioLevel,
  output logic              maskEnable,
  output logic              indexWide
);

  statusStrobes_t    strobes;
  logic [FLAG_W-1:0] flagQ;
  logic [IPL_W-1:0]  iplQ;

  proc_status_ctrl u_ctrl (
    .aluFlagEn (aluFlagEn),
    .maskSet   (maskSet),
    .maskClr   (maskClr),
    .maskBits  (maskBits),
    .carrySet  (carrySet),
    .carryClr  (carryClr),
    .intDisSet (intDisSet),
    .intDisClr (intDisClr),
    .irqAccept (irqAccept),
    .wrEn      (wrEn),
    .strobes   (strobes)
  );

  proc_status_path u_path (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .wrData   (wrData),
    .aluFlags (aluFlags),
    .flagQ    (flagQ),
    .iplQ     (iplQ),
    .rdData   (rdData)
  );

  assign carry       = flagQ[CARRY_BIT];
  assign zero        = flagQ[ZERO_BIT];
  assign intDisable  = flagQ[IDIS_BIT];
  assign decimalMode = flagQ[DEC_BIT];
  assign indexNarrow = flagQ[IDX_BIT];
  assign accNarrow   = flagQ[ACC_BIT];
  assign overflow    = flagQ[OVF_BIT];
  assign negative    = flagQ[NEG_BIT];
  assign prioLevel   = iplQ;
  assign maskEnable  = ~flagQ[IDIS_BIT];
  assign indexWide   = ~flagQ[IDX_BIT];

endmodule

// File: rtl/proc_status_chk.sv
module proc_status_chk
  import proc_status_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [FLAG_W-1:0] aluFlagEn,
  input logic              maskSet,
  input logic              maskClr,
  input logic [FLAG_W-1:0] maskBits,
  input logic              carrySet,
  input logic              carryClr,
  input logic              intDisSet,
  input logic              intDisClr,
  input logic              irqAccept,
  input logic              wrEn,
  input logic [BUS_W-1:0]  rdData,
  input logic              intDisable,
  input logic              maskEnable
);

  logic pastRst;
  always_ff @(posedge clk) pastRst <= rst;

  // R3
  always @(posedge clk) begin
    if (pastRst === 1'b1) begin
      reset_value_chk: assert (rdData == BUS_W'(FLAG_RESET))
        else $error("reset value wrong: %h", rdData);
    end
  end

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rdData[BUS_W-1 -: PAD_W] == '0);

  // R4
  irq_sets_idis_chk: assert property (@(posedge clk) disable iff (rst)
    irqAccept |=> intDisable);

  // R5
  mask_enable_chk: assert property (@(posedge clk) disable iff (rst)
    maskEnable != intDisable);

  // R6
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    maskSet |=> ((rdData[FLAG_W-1:0] & $past(maskBits)) == $past(maskBits)));

  // R7
  mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (maskClr && !maskSet && !carrySet && !intDisSet && !irqAccept)
      |=> ((rdData[FLAG_W-1:0] & $past(maskBits)) == '0));

  // R9
  ipl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> $stable(rdData[FLAG_W +: IPL_W]));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wrEn && !maskSet && !maskClr && !carrySet && !carryClr && !intDisSet &&
     !intDisClr && !irqAccept && aluFlagEn == '0) |=> $stable(rdData));

endmodule

bind proc_status proc_status_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .aluFlagEn  (aluFlagEn),
  .maskSet    (maskSet),
  .maskClr    (maskClr),
  .maskBits   (maskBits),
  .carrySet   (carrySet),
  .carryClr   (carryClr),
  .intDisSet  (intDisSet),
  .intDisClr  (intDisClr),
  .irqAccept  (irqAccept),
  .wrEn       (wrEn),
  .rdData     (rdData),
  .intDisable (intDisable),
  .maskEnable (maskEnable)
);

// File: tb/proc_status_bench.sv
module proc_status_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  aluFlagEn, aluFlags, maskBits;
  logic        maskSet, maskClr, carrySet, carryClr, intDisSet, intDisClr;
  logic        irqAccept, wrEn;
  logic [15:0] wrData, rdData;
  logic        carry, zero, intDisable, decimalMode, indexNarrow, accNarrow;
  logic        overflow, negative, maskEnable, indexWide;
  logic [2:0]  prioLevel;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  proc_status u_proc_status (
    .clk(clk), .rst(rst), .aluFlagEn(aluFlagEn), .aluFlags(aluFlags),
    .maskSet(maskSet), .maskClr(maskClr), .maskBits(maskBits),
    .carrySet(carrySet), .carryClr(carryClr), .intDisSet(intDisSet),
    .intDisClr(intDisClr), .irqAccept(irqAccept), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .carry(carry), .zero(zero),
    .intDisable(intDisable), .decimalMode(decimalMode),
    .indexNarrow(indexNarrow), .accNarrow(accNarrow), .overflow(overflow),
    .negative(negative), .prioLevel(prioLevel), .maskEnable(maskEnable),
    .indexWide(indexWide)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    rst = 0; aluFlagEn = 0; aluFlags = 0; maskBits = 0; maskSet = 0; maskClr = 0;
    carrySet = 0; carryClr = 0; intDisSet = 0; intDisClr = 0; irqAccept = 0;
    wrEn = 0; wrData = 0;
  endtask

  // stimulus already driven at a falling edge; let one rising edge pass
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic doWrite(input logic [15:0] d);
    wrEn = 1; wrData = d; step();
  endtask

  task automatic testReset();
    rst = 1; wrEn = 1; wrData = 16'hFFFF; step();
    chk("R3 reset value", rdData, 16'h0004);
    chk("R5 mask enable after reset", {15'd0, maskEnable}, 16'h0000);
    chk("R5 index wide after reset", {15'd0, indexWide}, 16'h0001);
  endtask

  task automatic testLayout();
    doWrite(16'hFFFF);
    chk("R2 upper bits zero", rdData, 16'h07FF);
    chk("R1 priority level", {13'd0, prioLevel}, 16'h0007);
    doWrite(16'h00A5);
    chk("R1 bus after write", rdData, 16'h00A5);
    chk("R1 individual flags",
        {8'd0, negative, overflow, accNarrow, indexNarrow, decimalMode, intDisable, zero, carry},
        16'h00A5);
    doWrite(16'h0010);
    chk("R5 narrow index and mask enable", {14'd0, indexWide, maskEnable}, 16'h0001);
  endtask

  task automatic testMask();
    doWrite(16'h00A5);
    maskClr = 1; maskBits = 8'h81; step();
    chk("R7 mask clear", rdData, 16'h0024);
    maskSet = 1; maskBits = 8'h18; step();
    chk("R6 mask set", rdData, 16'h003C);
    maskSet = 1; maskClr = 1; maskBits = 8'h03; step();
    chk("R7 set wins over clear", rdData, 16'h003F);
  endtask

  task automatic testDedicated();
    carryClr = 1; step();
    chk("R8 carry clear", rdData, 16'h003E);
    intDisClr = 1; step();
    chk("R8 idis clear", rdData, 16'h003A);
    carrySet = 1; carryClr = 1; step();
    chk("R8 carry set wins", rdData, 16'h003B);
    intDisSet = 1; step();
    chk("R8 idis set", rdData, 16'h003F);
  endtask

  task automatic testIrq();
    doWrite(16'h0300);
    chk("R9 write with level 3", rdData, 16'h0300);
    irqAccept = 1; intDisClr = 1; aluFlagEn = 8'h01; aluFlags = 8'h01; step();
    chk("R4 irq sets idis, alu on carry", rdData, 16'h0305);
    chk("R5 mask enable low after irq", {15'd0, maskEnable}, 16'h0000);
  endtask

  task automatic testPriority();
    wrEn = 1; wrData = 16'h0000; maskSet = 1; maskBits = 8'h80; step();
    chk("R9 mask set over write", rdData, 16'h0080);
    wrEn = 1; wrData = 16'h00FF; maskClr = 1; maskBits = 8'h0F; step();
    chk("R9 mask clear over write", rdData, 16'h00F0);
    wrEn = 1; wrData = 16'h0000; aluFlagEn = 8'hFF; aluFlags = 8'hFF; step();
    chk("R10 write over alu", rdData, 16'h0000);
  endtask

  task automatic testAlu();
    aluFlagEn = 8'hC3; aluFlags = 8'h41; step();
    chk("R10 alu enabled bits", rdData, 16'h0041);
    aluFlagEn = 8'h02; aluFlags = 8'hFD; step();
    chk("R10 alu bit cleared", rdData, 16'h0041);
    aluFlagEn = 8'h7D; aluFlags = 8'h00; maskSet = 1; maskBits = 8'h01; step();
    chk("R10 mask over alu", rdData, 16'h0001);
    doWrite(16'h0700);
    aluFlagEn = 8'hFF; aluFlags = 8'hFF; step();
    chk("R10 alu keeps level", rdData, 16'h07FF);
  endtask

  task automatic testHold();
    step(); step(); step();
    chk("R11 hold when idle", rdData, 16'h07FF);
    rst = 1; maskSet = 1; maskBits = 8'hFF; step();
    chk("R3 reset over mask set", rdData, 16'h0004);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    @(negedge clk);
    testReset();
    testLayout();
    testMask();
    testDedicated();
    testIrq();
    testPriority();
    testAlu();
    testHold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule